// File: doc/BRIEF.md
# Multithreaded Stream Issue Scheduler

This block chooses, in every clock cycle, which of a pool of hardware instruction-stream contexts gets the single issue slot. A stream takes part only while it is active and its next operation can proceed. When one stream has to wait on memory, the slot goes to another ready stream in the same cycle, with no switch penalty. That is how memory latency is hidden. With 128 streams and up to 8 references in flight per stream, a memory round trip of up to 1024 cycles can be covered without losing issue slots, as long as enough streams are ready.

Each stream has an outstanding-reference counter. It goes up when the stream issues a new memory operation and down when a completion tagged with that stream returns. A stream whose counter has reached the limit cannot issue further memory operations, but it can still issue operations that are not memory operations. The memory side can refuse a reference. The refused stream ID and reference tag then go into a first-in first-out retry queue. From there the reference is reissued ahead of every new issue whenever the memory side is accepting. The issue output carries the stream ID, a flag marking a replay, and the reference tag.

The search for a new issue starts one position past the stream that last issued normally. Every ready stream is therefore served in turn. The outputs are combinational from the current inputs and the registered state. All state changes at the clock edge that ends the cycle.

Top module: `stream_issue_sched`

## Requirements
- R1: While reset is applied, issue_vld is low. After reset is released, the first new issue searches from stream 0, every outstanding counter and tag sequence is zero, and the retry queue is empty.
- R2: A stream can be chosen for a new issue only when both its strm_active and strm_ready bits are 1. If its strm_is_mem bit is 1, it also needs an outstanding count below MAX_OUT and mem_accept high. When no stream qualifies and no retry can go, issue_vld is 0.
- R3: The search for a new issue begins at the stream one index above the last stream that issued normally, wrapping from N_STREAMS-1 to 0. A different stream can issue in each consecutive cycle with no idle gap.
- R4: A new memory issue adds one to that stream's outstanding count, and a completion (cpl_vld with cpl_id) subtracts one. At MAX_OUT (8 by default), the stream's memory operations are held back while its non-memory operations still issue.
- R5: When a new memory issue and a completion hit the same stream in the same cycle, its outstanding count does not change.
- R6: A refusal (rej_vld with rej_id, rej_tag) is queued. In any cycle with mem_accept high and the queue not empty, the queue head takes the slot with issue_retry=1, its stored ID and tag, ahead of any new issue. While mem_accept is low, no retry goes out and streams with non-memory operations keep issuing. A replay does not change any outstanding count.
- R7: A new memory issue carries as issue_tag the stream's sequence number. This number starts at 0, goes up by one with each new memory issue of that stream, and wraps from MAX_OUT-1 to 0. A non-memory issue carries tag 0.
- R8: Queued retries leave in the order in which they were refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| strm_active | input | N_STREAMS | Bit per stream: context holds a live instruction stream |
| strm_ready | input | N_STREAMS | Bit per stream: next operation is not waiting |
| strm_is_mem | input | N_STREAMS | Bit per stream: next operation is a memory reference |
| mem_accept | input | 1 | Memory side can take a reference this cycle |
| cpl_vld | input | 1 | A memory completion returns this cycle |
| cpl_id | input | ID_W | Stream ID of the completion |
| rej_vld | input | 1 | A reference was refused and must be replayed |
| rej_id | input | ID_W | Stream ID of the refused reference |
| rej_tag | input | TAG_W | Tag of the refused reference |
| issue_vld | output | 1 | Issue strobe for this cycle |
| issue_id | output | ID_W | Stream ID granted the slot |
| issue_retry | output | 1 | The slot replays a queued reference |
| issue_tag | output | TAG_W | Reference tag of the issued operation |

## Verification
A wrong outstanding count is visible at the ports only indirectly. The stream either stops issuing memory operations too early or issues a ninth one. That shows up in the first cycle in which the stream asks for memory at the limit. So the bench drives one stream to the limit and then crosses a completion with an issue. A corrupt rotation pointer shows up on the next new issue as a repeated or skipped stream ID. A lost or misordered retry entry shows up in the first cycle mem_accept is high, as a missing replay or a wrong ID and tag.

// File: rtl/ssch_pkg.sv
package ssch_pkg;

  // What the single issue slot carries in a cycle.
  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_NEW   = 2'd1,
    SLOT_RETRY = 2'd2
  } slot_kind_e;

endpackage

// File: rtl/ssch_credit.sv
// Per-stream outstanding-reference counters and tag sequence numbers.
module ssch_credit #(
  parameter int N_STREAMS = 128,
  parameter int MAX_OUT   = 8,
  parameter int ID_W      = $clog2(N_STREAMS),
  parameter int TAG_W     = $clog2(MAX_OUT),
  parameter int CNT_W     = $clog2(MAX_OUT + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inc_vld,
  input  logic [ID_W-1:0]          inc_id,
  input  logic                     dec_vld,
  input  logic [ID_W-1:0]          dec_id,
  output logic [N_STREAMS-1:0]     at_limit,
  output logic [N_STREAMS*TAG_W-1:0] seq_flat
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUT);
  localparam logic [TAG_W-1:0] SEQ_TOP = TAG_W'(MAX_OUT - 1);

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_strm
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [TAG_W-1:0] seq_q, seq_d;
    logic             hit_inc, hit_dec, cnt_en;

    assign hit_inc = inc_vld && (inc_id == ID_W'(s));
    assign hit_dec = dec_vld && (dec_id == ID_W'(s));
    assign cnt_en  = hit_inc ^ hit_dec;

    always_comb begin
      cnt_d = cnt_q;
      if (hit_inc && !hit_dec) begin
        cnt_d = cnt_q + 1'b1;
      end else if (hit_dec && !hit_inc) begin
        cnt_d = cnt_q - 1'b1;
      end
      seq_d = (seq_q == SEQ_TOP) ? '0 : seq_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seq_q <= '0;
      end else if (hit_inc) begin
        seq_q <= seq_d;
      end
    end

    assign at_limit[s]                   = (cnt_q == CNT_MAX);
    assign seq_flat[s*TAG_W +: TAG_W]    = seq_q;

    // R4: the count never passes the per-stream limit
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX);
    // R4: a completion never arrives for a stream with nothing in flight
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_dec && !hit_inc) |-> (cnt_q != '0));
    // R5: crossing increment and decrement keep the count
    a_r5_cross_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_inc && hit_dec) |=> $stable(cnt_q));
  end

endmodule

// File: rtl/ssch_rr_pick.sv
// Rotating-priority search over the eligible streams.
module ssch_rr_pick #(
  parameter int N_STREAMS = 128,
  parameter int ID_W      = $clog2(N_STREAMS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_STREAMS-1:0] req,
  input  logic                 adv,
  output logic                 gnt_vld,
  output logic [ID_W-1:0]      gnt_id
);

  localparam logic [ID_W-1:0] LAST_RST = ID_W'(N_STREAMS - 1);

  logic [ID_W-1:0] last_q;

  always_comb begin
    gnt_vld = 1'b0;
    gnt_id  = '0;
    for (int k = 0; k < N_STREAMS; k++) begin
      int pos;
      pos = int'(last_q) + 1 + k;
      if (pos >= N_STREAMS) pos = pos - N_STREAMS;
      if (!gnt_vld && req[pos]) begin
        gnt_vld = 1'b1;
        gnt_id  = ID_W'(pos);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= LAST_RST;
    end else if (adv) begin
      last_q <= gnt_id;
    end
  end

  // R2: a grant always lands on a requesting stream
  a_r2_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> req[gnt_id]);
  // R2: no grant only when nothing requests
  a_r2_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_vld |-> (req == '0));

endmodule

// File: rtl/ssch_retry_q.sv
// First-in first-out pool of refused references awaiting replay.
module ssch_retry_q #(
  parameter int DEPTH = 16,
  parameter int ENT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ENT_W-1:0] push_ent,
  input  logic             pop,
  output logic             vld,
  output logic [ENT_W-1:0] head
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [ENT_W-1:0] ent_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop, cnt_en;

  assign do_pop  = pop && (cnt_q != '0);
  assign do_push = push && ((cnt_q != CNT_FULL) || do_pop);
  assign cnt_en  = do_push ^ do_pop;

  always_comb begin
    wr_d  = (wr_q == PTR_TOP) ? '0 : wr_q + 1'b1;
    rd_d  = (rd_q == PTR_TOP) ? '0 : rd_q + 1'b1;
    cnt_d = do_push ? cnt_q + 1'b1 : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
    end else if (do_push) begin
      wr_q <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (do_pop) begin
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      ent_q[wr_q] <= push_ent;
    end
  end

  assign vld  = (cnt_q != '0);
  assign head = ent_q[rd_q];

  // R6: the memory side never refuses into a full pool
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((cnt_q != CNT_FULL) || pop));
  // R8: occupancy stays within the pool
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  // R8: the head entry stays put until it is taken
  a_r8_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !pop) |=> $stable(head));

endmodule

// File: rtl/stream_issue_sched.sv
module stream_issue_sched
  import ssch_pkg::*;
#(
  parameter int N_STREAMS = 128,
  parameter int MAX_OUT   = 8,
  parameter int RQ_DEPTH  = 16,
  localparam int ID_W     = $clog2(N_STREAMS),
  localparam int TAG_W    = $clog2(MAX_OUT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_STREAMS-1:0] strm_active,
  input  logic [N_STREAMS-1:0] strm_ready,
  input  logic [N_STREAMS-1:0] strm_is_mem,
  input  logic                 mem_accept,
  input  logic                 cpl_vld,
  input  logic [ID_W-1:0]      cpl_id,
  input  logic                 rej_vld,
  input  logic [ID_W-1:0]      rej_id,
  input  logic [TAG_W-1:0]     rej_tag,
  output logic                 issue_vld,
  output logic [ID_W-1:0]      issue_id,
  output logic                 issue_retry,
  output logic [TAG_W-1:0]     issue_tag
);

  localparam int ENT_W = ID_W + TAG_W;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q, rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ni     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ni     <= rst_meta_q;
    end
  end

  logic [N_STREAMS-1:0]       at_limit;
  logic [N_STREAMS*TAG_W-1:0] seq_flat;
  logic [N_STREAMS-1:0]       mem_ok, elig;
  logic                       gnt_vld, adv, new_mem, pop;
  logic [ID_W-1:0]            gnt_id, rq_id;
  logic [TAG_W-1:0]           rq_tag, seq_sel;
  logic                       rq_vld;
  logic [ENT_W-1:0]           rq_head;
  slot_kind_e                 kind;

  assign mem_ok = ~at_limit & {N_STREAMS{mem_accept}};
  assign elig   = strm_active & strm_ready & (~strm_is_mem | mem_ok);

  ssch_rr_pick #(
    .N_STREAMS (N_STREAMS),
    .ID_W      (ID_W)
  ) i_pick (
    .clk     (clk),
    .rst_n   (rst_ni),
    .req     (elig),
    .adv     (adv),
    .gnt_vld (gnt_vld),
    .gnt_id  (gnt_id)
  );

  ssch_retry_q #(
    .DEPTH (RQ_DEPTH),
    .ENT_W (ENT_W)
  ) i_rq (
    .clk      (clk),
    .rst_n    (rst_ni),
    .push     (rej_vld),
    .push_ent ({rej_id, rej_tag}),
    .pop      (pop),
    .vld      (rq_vld),
    .head     (rq_head)
  );

  assign rq_id  = rq_head[ENT_W-1:TAG_W];
  assign rq_tag = rq_head[TAG_W-1:0];

  ssch_credit #(
    .N_STREAMS (N_STREAMS),
    .MAX_OUT   (MAX_OUT),
    .ID_W      (ID_W),
    .TAG_W     (TAG_W)
  ) i_credit (
    .clk      (clk),
    .rst_n    (rst_ni),
    .inc_vld  (new_mem),
    .inc_id   (gnt_id),
    .dec_vld  (cpl_vld),
    .dec_id   (cpl_id),
    .at_limit (at_limit),
    .seq_flat (seq_flat)
  );

  assign seq_sel = seq_flat[int'(gnt_id)*TAG_W +: TAG_W];

  // Slot decision: a queued replay wins over every new issue.
  always_comb begin
    if (!rst_ni) begin
      kind = SLOT_IDLE;
    end else if (rq_vld && mem_accept) begin
      kind = SLOT_RETRY;
    end else if (gnt_vld) begin
      kind = SLOT_NEW;
    end else begin
      kind = SLOT_IDLE;
    end
  end

  assign adv     = (kind == SLOT_NEW);
  assign pop     = (kind == SLOT_RETRY);
  assign new_mem = adv && strm_is_mem[gnt_id];

  always_comb begin
    issue_vld   = (kind != SLOT_IDLE);
    issue_retry = pop;
    issue_id    = pop ? rq_id : gnt_id;
    if (pop) begin
      issue_tag = rq_tag;
    end else if (new_mem) begin
      issue_tag = seq_sel;
    end else begin
      issue_tag = '0;
    end
  end

  // One cycle after reset release, $past values are meaningful.
  logic seen_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
    end
  end

  // R1: no issue while the block is held in reset
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_ni |-> !issue_vld);
  // R2: a new issue names an active, ready stream
  a_r2_issue_live: assert property (@(posedge clk) disable iff (!rst_ni)
    (issue_vld && !issue_retry) |-> (strm_active[issue_id] && strm_ready[issue_id]));
  // R3: with a rival eligible, the last new issuer does not win again
  a_r3_rotate: assert property (@(posedge clk) disable iff (!rst_ni)
    (seen_q && adv && $past(adv) && ($countones(elig) > 1)) |-> (issue_id != $past(gnt_id)));
  // R6: a pending replay goes first whenever memory accepts
  a_r6_retry_first: assert property (@(posedge clk) disable iff (!rst_ni)
    (rq_vld && mem_accept) |-> (issue_vld && issue_retry));
  // R6: no replay while memory refuses
  a_r6_retry_waits: assert property (@(posedge clk) disable iff (!rst_ni)
    !mem_accept |-> !issue_retry);
  // R4: no memory issue leaves while memory refuses
  a_r4_mem_gated: assert property (@(posedge clk) disable iff (!rst_ni)
    (issue_vld && !issue_retry && strm_is_mem[issue_id]) |-> mem_accept);

endmodule

// File: tb/test_stream_issue_sched.sv
module test_stream_issue_sched;

  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int MAXO  = 8;
  localparam int DEP   = 4;
  localparam int ID_W  = $clog2(N);
  localparam int TAG_W = $clog2(MAXO);

  logic             clk;
  logic             rst_n;
  logic [N-1:0]     strm_active, strm_ready, strm_is_mem;
  logic             mem_accept, cpl_vld, rej_vld;
  logic [ID_W-1:0]  cpl_id, rej_id;
  logic [TAG_W-1:0] rej_tag;
  logic             issue_vld, issue_retry;
  logic [ID_W-1:0]  issue_id;
  logic [TAG_W-1:0] issue_tag;

  int n_chk;
  int n_bad;
  bit done;

  stream_issue_sched #(
    .N_STREAMS (N),
    .MAX_OUT   (MAXO),
    .RQ_DEPTH  (DEP)
  ) i_stream_issue_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .strm_active (strm_active),
    .strm_ready  (strm_ready),
    .strm_is_mem (strm_is_mem),
    .mem_accept  (mem_accept),
    .cpl_vld     (cpl_vld),
    .cpl_id      (cpl_id),
    .rej_vld     (rej_vld),
    .rej_id      (rej_id),
    .rej_tag     (rej_tag),
    .issue_vld   (issue_vld),
    .issue_id    (issue_id),
    .issue_retry (issue_retry),
    .issue_tag   (issue_tag)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // Round-robin stimulus, non-memory operations only, walked from reset.
  typedef struct packed {
    logic [7:0] act;
    logic [7:0] rdy;
    logic       ev;
    logic [2:0] eid;
  } row_t;

  localparam row_t TBL [10] = '{
    '{8'hFF, 8'hFF, 1'b1, 3'd0},  // R1: first search starts at 0
    '{8'hFF, 8'hFF, 1'b1, 3'd1},  // R3: next stream, no gap
    '{8'hFF, 8'h81, 1'b1, 3'd7},  // R3: search from 2 reaches 7
    '{8'hFF, 8'h81, 1'b1, 3'd0},  // R3: wrap to 0
    '{8'hFF, 8'h00, 1'b0, 3'd0},  // R2: none ready
    '{8'h10, 8'hFF, 1'b1, 3'd4},  // R2: only active stream
    '{8'h0F, 8'hF0, 1'b0, 3'd0},  // R2: active and ready disjoint
    '{8'hFF, 8'h24, 1'b1, 3'd5},  // R3: from 5
    '{8'hFF, 8'h24, 1'b1, 3'd2},  // R3: rotate past 5 to 2
    '{8'hFF, 8'h04, 1'b1, 3'd2}   // R3: lone stream repeats
  };

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic drive(input logic [N-1:0] act, input logic [N-1:0] rdy,
                       input logic [N-1:0] mem, input logic acc,
                       input logic cv, input logic [ID_W-1:0] ci,
                       input logic rv, input logic [ID_W-1:0] ri,
                       input logic [TAG_W-1:0] rt);
    @(posedge clk);
    #1;
    strm_active = act;
    strm_ready  = rdy;
    strm_is_mem = mem;
    mem_accept  = acc;
    cpl_vld     = cv;
    cpl_id      = ci;
    rej_vld     = rv;
    rej_id      = ri;
    rej_tag     = rt;
  endtask

  task automatic chk(input logic ev, input logic [ID_W-1:0] eid, input logic er,
                     input logic [TAG_W-1:0] et, input string req);
    n_chk++;
    if (issue_vld !== ev ||
        (ev && (issue_id !== eid || issue_retry !== er || issue_tag !== et))) begin
      n_bad++;
      $display("FAIL %s: got vld=%0b id=%0d retry=%0b tag=%0d, expected vld=%0b id=%0d retry=%0b tag=%0d",
               req, issue_vld, issue_id, issue_retry, issue_tag, ev, eid, er, et);
    end
  endtask

  task automatic step(input logic [N-1:0] act, input logic [N-1:0] rdy,
                      input logic [N-1:0] mem, input logic acc,
                      input logic cv, input logic [ID_W-1:0] ci,
                      input logic rv, input logic [ID_W-1:0] ri,
                      input logic [TAG_W-1:0] rt,
                      input logic ev, input logic [ID_W-1:0] eid, input logic er,
                      input logic [TAG_W-1:0] et, input string req);
    drive(act, rdy, mem, acc, cv, ci, rv, ri, rt);
    @(negedge clk);
    chk(ev, eid, er, et, req);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got no end of test, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    strm_active = '0; strm_ready = '0; strm_is_mem = '0;
    mem_accept = 1'b0; cpl_vld = 1'b0; cpl_id = '0;
    rej_vld = 1'b0; rej_id = '0; rej_tag = '0;

    // R1: strobe low during reset even with every stream ready
    drive(8'hFF, 8'hFF, 8'h00, 1'b1, 1'b0, 0, 1'b0, 0, 0);
    @(negedge clk);
    chk(1'b0, 0, 1'b0, 0, "R1 reset");
    @(posedge clk);
    #1 rst_n = 1'b1;
    strm_active = '0;
    repeat (3) @(posedge clk);

    for (int i = 0; i < 10; i++) begin
      step(TBL[i].act, TBL[i].rdy, 8'h00, 1'b1, 1'b0, 0, 1'b0, 0, 0,
           TBL[i].ev, TBL[i].eid, 1'b0, 0, $sformatf("R3/R2 row %0d", i));
    end

    // R4, R7: stream 3 fills its window; tags count 0..7
    for (int k = 0; k < MAXO; k++) begin
      step(8'h08, 8'h08, 8'h08, 1'b1, 1'b0, 0, 1'b0, 0, 0,
           1'b1, 3, 1'b0, TAG_W'(k), "R7 tag sequence");
    end
    step(8'h08, 8'h08, 8'h08, 1'b1, 1'b0, 0, 1'b0, 0, 0,
         1'b0, 0, 1'b0, 0, "R4 held at limit");
    step(8'h08, 8'h08, 8'h00, 1'b1, 1'b0, 0, 1'b0, 0, 0,
         1'b1, 3, 1'b0, 0, "R4 non-memory op at limit");
    step(8'h08, 8'h08, 8'h08, 1'b1, 1'b1, 3, 1'b0, 0, 0,
         1'b0, 0, 1'b0, 0, "R4 completion takes effect next cycle");
    step(8'h08, 8'h08, 8'h08, 1'b1, 1'b1, 3, 1'b0, 0, 0,
         1'b1, 3, 1'b0, 0, "R7 tag wrap");
    step(8'h08, 8'h08, 8'h08, 1'b1, 1'b0, 0, 1'b0, 0, 0,
         1'b1, 3, 1'b0, 1, "R5 one slot left");
    step(8'h08, 8'h08, 8'h08, 1'b1, 1'b0, 0, 1'b0, 0, 0,
         1'b0, 0, 1'b0, 0, "R5 crossing kept the count");

    // R6, R8: refusals queue while memory stalls; non-memory work continues
    step(8'h02, 8'h02, 8'h00, 1'b0, 1'b0, 0, 1'b1, 5, 2,
         1'b1, 1, 1'b0, 0, "R6 issue continues, memory stalled");
    step(8'h02, 8'h02, 8'h00, 1'b0, 1'b0, 0, 1'b1, 6, 5,
         1'b1, 1, 1'b0, 0, "R6 no replay while stalled");
    step(8'h20, 8'h20, 8'h20, 1'b1, 1'b0, 0, 1'b0, 0, 0,
         1'b1, 5, 1'b1, 2, "R6 replay before new issue");
    step(8'h20, 8'h20, 8'h20, 1'b1, 1'b0, 0, 1'b0, 0, 0,
         1'b1, 6, 1'b1, 5, "R8 replay order");
    step(8'h20, 8'h20, 8'h20, 1'b1, 1'b0, 0, 1'b0, 0, 0,
         1'b1, 5, 1'b0, 0, "R7 new issue after replays");

    // R1: reset mid-run clears pool, pointer and counters
    step(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 0, 1'b1, 2, 1,
         1'b0, 0, 1'b0, 0, "R2 nothing active");
    drive(8'hFF, 8'hFF, 8'h00, 1'b1, 1'b0, 0, 1'b0, 0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(1'b0, 0, 1'b0, 0, "R1 strobe low in reset");
    @(posedge clk);
    #1 rst_n = 1'b1;
    strm_active = '0;
    repeat (3) @(posedge clk);
    step(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 0, 1'b0, 0, 0,
         1'b0, 0, 1'b0, 0, "R1 retry pool empty");
    step(8'hFF, 8'hFF, 8'h00, 1'b1, 1'b0, 0, 1'b0, 0, 0,
         1'b1, 0, 1'b0, 0, "R1 pointer restarts at 0");
    step(8'h08, 8'h08, 8'h08, 1'b1, 1'b0, 0, 1'b0, 0, 0,
         1'b1, 3, 1'b0, 0, "R1 counters and tags cleared");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule